// File: doc/BRIEF.md
# Two-Trim Fuse Preset Controller

This block owns the 8-bit code that sets the wiper of a 256-step resistor ladder. It receives commands that a serial front end has already decoded. Each command carries a data byte and five control flags:

- a data-present qualifier,
- a trim-select flag,
- a shutdown flag,
- a burn flag,
- an overwrite flag.

Two one-shot trim arrays stand in for the fuse storage. Each array can be burned once to hold a code for good. A burn lasts a fixed window of clock cycles. During that window the block is busy and takes no other command. In place of the real fuse physics, the bench drives a pass/fail input that gives the outcome of each burn.

Before any fuse is burned, the wiper code behaves as a volatile register. It comes up at midscale and may be rewritten any number of times. Once a trim holds a code, that code becomes the wiper setting and the power-on preset. An overwrite mode lets software move the wiper away from the fused code for a while. Clearing that mode returns the wiper to the fused code. Shutdown turns the ladder off but keeps every stored code.

Two resets are provided:

- `rst_ni` models a power cycle. It clears the volatile state and leaves the trims untouched.
- `blank_ni` models a fresh, unprogrammed die. It clears the trims as well.

Top module: `trim_preset_ctrl`

## Requirements
- R1: After `rst_ni` with no trim burned, `wiper_o` is 0x80, `shutdown_o` is 0, `busy_o` is 0 and `status_o` is 2'b00 (ready).
- R2: With no trim burned, an accepted command with burn=0 and data present loads `cmd_data_i` into the wiper code, visible on the next cycle, any number of times; the overwrite flag has no effect here.
- R3: An accepted burn command holds `busy_o` high for exactly BURN_CYCLES cycles; every command presented while `busy_o` is high is ignored, shutdown included.
- R4: `cmd_sel2_i`=0 burns trim 1 and 1 burns trim 2 with `cmd_data_i`; on success `status_o` becomes 2'b11 (bit 1 = first validation bit, bit 0 = second) and the wiper shows the fused code; a burned trim 2 takes precedence over trim 1; after `rst_ni` the wiper presets to that fused code.
- R5: With a trim burned, a data write with overwrite=0 leaves the wiper at the fused code.
- R6: With a trim burned, a data write with overwrite=1 sets the wiper to the new code; any later command with overwrite=0 returns the wiper to the fused code; `rst_ni` also clears the overwrite.
- R7: Burning trim 2 while trim 1 is unburned locks trim 1; a later burn of trim 1 is refused (`busy_o` stays 0 and the wiper is unchanged); no burn is accepted once trim 2 holds a code.
- R8: A failed burn sets `status_o` to 2'b10; from then on every burn request is refused; the fatal status survives `rst_ni`; 2'b01 never appears.
- R9: A command with the shutdown flag set drives `shutdown_o`=1 and `wiper_o`=0x00 while the stored codes keep taking writes; a later command with shutdown=0 shows the last stored code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-cycle reset (volatile state) |
| blank_ni | input | 1 | Asynchronous active-low reset of the trim arrays (fresh die) |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_data_en_i | input | 1 | Command carries a data byte |
| cmd_sel2_i | input | 1 | Burn target: 0 trim 1, 1 trim 2 |
| cmd_sd_i | input | 1 | Shutdown request |
| cmd_burn_i | input | 1 | Permanent-program request |
| cmd_ow_i | input | 1 | Overwrite mode |
| cmd_data_i | input | 8 | Data byte |
| burn_ok_i | input | 1 | Burn outcome, sampled on the last busy cycle |
| wiper_o | output | 8 | Code applied to the ladder |
| shutdown_o | output | 1 | Ladder shut down |
| status_o | output | 2 | Validation bits: 00 ready, 10 fatal, 11 programmed |
| busy_o | output | 1 | Burn window in progress |

## Verification
The assertions rely on a few assumptions about the inputs:

- each command is a single-cycle strobe;
- `burn_ok_i` matters only on the last cycle of a burn window;
- `rst_ni` is never pulsed in the middle of a burn;
- `blank_ni` falls only together with `rst_ni`.

The stimulus respects all of these. It waits for `busy_o` to clear before each new burn, except where it deliberately sends a command into the busy window to show that the command is dropped. It also lowers `blank_ni` only inside a full reset pulse that lasts two cycles.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'b00,
    ST_FATAL = 2'b10,
    ST_DONE  = 2'b11
  } status_e;

  typedef struct packed {
    logic data_en;
    logic sel2;
    logic sd;
    logic burn;
    logic ow;
  } cmd_flags_t;
endpackage

// File: rtl/trim_burn_timer.sv
module trim_burn_timer #(
  parameter int unsigned BURN_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(BURN_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(BURN_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/trim_fuse_bank.sv
module trim_fuse_bank
  import trim_pkg::*;
#(
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned N_TRIMS = 2,
  localparam int unsigned SEL_W  = (N_TRIMS > 1) ? $clog2(N_TRIMS) : 1
) (
  input  logic              clk_i,
  input  logic              blank_ni,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              done_i,
  input  logic              ok_i,
  output logic              allowed_o,
  output logic              fused_o,
  output logic [CODE_W-1:0] fused_code_o,
  output status_e           status_o
);
  logic [N_TRIMS-1:0] blown_q;
  logic [N_TRIMS-1:0] locked_q;
  logic [N_TRIMS-1:0] above_blown;
  logic [CODE_W-1:0]  code_q [N_TRIMS];
  logic [SEL_W-1:0]   pend_sel_q;
  logic [CODE_W-1:0]  pend_code_q;
  logic               fatal_q;

  // a slot is closed once any later slot holds a code
  for (genvar i = 0; i < N_TRIMS; i++) begin : g_above
    if (i == N_TRIMS - 1) begin : g_top
      assign above_blown[i] = 1'b0;
    end else begin : g_mid
      assign above_blown[i] = |blown_q[N_TRIMS-1:i+1];
    end
  end

  assign allowed_o = !fatal_q && !blown_q[sel_i] && !locked_q[sel_i] && !above_blown[sel_i];

  always_comb begin
    fused_o      = 1'b0;
    fused_code_o = '0;
    for (int i = 0; i < N_TRIMS; i++) begin
      if (blown_q[i]) begin
        fused_o      = 1'b1;
        fused_code_o = code_q[i];
      end
    end
  end

  always_comb begin
    if (fatal_q)      status_o = ST_FATAL;
    else if (fused_o) status_o = ST_DONE;
    else              status_o = ST_READY;
  end

  always_ff @(posedge clk_i or negedge blank_ni) begin
    if (!blank_ni) begin
      blown_q     <= '0;
      locked_q    <= '0;
      pend_sel_q  <= '0;
      pend_code_q <= '0;
      fatal_q     <= 1'b0;
      for (int i = 0; i < N_TRIMS; i++) code_q[i] <= '0;
    end else begin
      if (start_i) begin
        pend_sel_q  <= sel_i;
        pend_code_q <= code_i;
        for (int i = 0; i < N_TRIMS; i++) begin
          if (int'(sel_i) > i && !blown_q[i]) locked_q[i] <= 1'b1;
        end
      end
      if (done_i) begin
        if (ok_i) begin
          blown_q[pend_sel_q] <= 1'b1;
          code_q[pend_sel_q]  <= pend_code_q;
        end else begin
          fatal_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trim_wiper_reg.sv
module trim_wiper_reg #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              data_en_i,
  input  logic              sd_i,
  input  logic              ow_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              fused_i,
  input  logic [CODE_W-1:0] fused_code_i,
  output logic [CODE_W-1:0] wiper_o,
  output logic              shutdown_o
);
  localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] vol_q;
  logic [CODE_W-1:0] ovr_code_q;
  logic              ovr_q;
  logic              sd_q;
  logic [CODE_W-1:0] active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q      <= MIDSCALE;
      ovr_code_q <= '0;
      ovr_q      <= 1'b0;
      sd_q       <= 1'b0;
    end else if (wr_i) begin
      sd_q <= sd_i;
      if (!ow_i) begin
        ovr_q <= 1'b0;
      end else if (data_en_i && fused_i) begin
        ovr_q      <= 1'b1;
        ovr_code_q <= data_i;
      end
      if (data_en_i && !fused_i) vol_q <= data_i;
    end
  end

  always_comb begin
    if (ovr_q)        active = ovr_code_q;
    else if (fused_i) active = fused_code_i;
    else              active = vol_q;
  end

  assign wiper_o    = sd_q ? '0 : active;
  assign shutdown_o = sd_q;
endmodule

// File: rtl/trim_preset_ctrl.sv
module trim_preset_ctrl
  import trim_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned BURN_CYCLES = 80_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blank_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_data_en_i,
  input  logic              cmd_sel2_i,
  input  logic              cmd_sd_i,
  input  logic              cmd_burn_i,
  input  logic              cmd_ow_i,
  input  logic [CODE_W-1:0] cmd_data_i,
  input  logic              burn_ok_i,
  output logic [CODE_W-1:0] wiper_o,
  output logic              shutdown_o,
  output logic [1:0]        status_o,
  output logic              busy_o
);
  localparam int unsigned N_TRIMS = 2;

  cmd_flags_t        flags;
  logic              busy;
  logic              done;
  logic              accept;
  logic              allowed;
  logic              burn_go;
  logic              wr_go;
  logic              fused;
  logic [CODE_W-1:0] fused_code;
  status_e           status;

  assign flags   = '{data_en: cmd_data_en_i, sel2: cmd_sel2_i, sd: cmd_sd_i,
                     burn: cmd_burn_i, ow: cmd_ow_i};
  assign accept  = cmd_valid_i && !busy;
  assign burn_go = accept && flags.burn && allowed;
  assign wr_go   = accept && !flags.burn;

  trim_burn_timer #(.BURN_CYCLES(BURN_CYCLES)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (burn_go),
    .busy_o  (busy),
    .done_o  (done)
  );

  trim_fuse_bank #(.CODE_W(CODE_W), .N_TRIMS(N_TRIMS)) i_bank (
    .clk_i        (clk_i),
    .blank_ni     (blank_ni),
    .start_i      (burn_go),
    .sel_i        (flags.sel2),
    .code_i       (cmd_data_i),
    .done_i       (done),
    .ok_i         (burn_ok_i),
    .allowed_o    (allowed),
    .fused_o      (fused),
    .fused_code_o (fused_code),
    .status_o     (status)
  );

  trim_wiper_reg #(.CODE_W(CODE_W)) i_wiper (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_go),
    .data_en_i    (flags.data_en),
    .sd_i         (flags.sd),
    .ow_i         (flags.ow),
    .data_i       (cmd_data_i),
    .fused_i      (fused),
    .fused_code_i (fused_code),
    .wiper_o      (wiper_o),
    .shutdown_o   (shutdown_o)
  );

  assign status_o = status;
  assign busy_o   = busy;
endmodule

// File: rtl/trim_preset_ctrl_chk.sv
module trim_preset_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       blank_ni,
  input logic       cmd_valid_i,
  input logic       cmd_burn_i,
  input logic [1:0] status_o,
  input logic       busy_o,
  input logic       shutdown_o
);
  AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni || !blank_ni)
    status_o != 2'b01); // R8

  AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni || !blank_ni)
    status_o == 2'b10 |=> status_o == 2'b10); // R8

  AST_FATAL_NO_BURN: assert property (@(posedge clk_i) disable iff (!rst_ni || !blank_ni)
    (status_o == 2'b10 && !busy_o) |=> !busy_o); // R8

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni || !blank_ni)
    status_o == 2'b11 |=> status_o[1]); // R4

  AST_BURN_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni || !blank_ni)
    $rose(busy_o) |-> $past(cmd_valid_i && cmd_burn_i)); // R3

  AST_BURN_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni || !blank_ni)
    $fell(busy_o) |-> status_o[1]); // R4

  AST_BUSY_HOLDS_SD: assert property (@(posedge clk_i) disable iff (!rst_ni || !blank_ni)
    busy_o |=> $stable(shutdown_o)); // R3
endmodule

bind trim_preset_ctrl trim_preset_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blank_ni    (blank_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_burn_i  (cmd_burn_i),
  .status_o    (status_o),
  .busy_o      (busy_o),
  .shutdown_o  (shutdown_o)
);

// File: tb/test_trim_preset_ctrl.sv
`timescale 1ns/1ps
module test_trim_preset_ctrl;
  localparam int unsigned BURN = 20;
  localparam int NVEC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blank_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_data_en = 1'b0;
  logic       cmd_sel2 = 1'b0;
  logic       cmd_sd = 1'b0;
  logic       cmd_burn = 1'b0;
  logic       cmd_ow = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       burn_ok = 1'b1;
  logic [7:0] wiper;
  logic       shutdown;
  logic [1:0] status;
  logic       busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  trim_preset_ctrl #(.CODE_W(8), .BURN_CYCLES(BURN)) i_trim_preset_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .blank_ni(blank_n),
    .cmd_valid_i(cmd_valid), .cmd_data_en_i(cmd_data_en), .cmd_sel2_i(cmd_sel2),
    .cmd_sd_i(cmd_sd), .cmd_burn_i(cmd_burn), .cmd_ow_i(cmd_ow), .cmd_data_i(cmd_data),
    .burn_ok_i(burn_ok), .wiper_o(wiper), .shutdown_o(shutdown),
    .status_o(status), .busy_o(busy)
  );

  // fields: data_en, sd, ow, data[7:0], exp_wiper[7:0], exp_sd
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 8'h12, 8'h12, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'h34, 8'h34, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'h55, 8'h00, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h55, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h9A, 8'h9A, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic de, input logic sel, input logic sd,
                      input logic burn, input logic ow, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data_en = de; cmd_sel2 = sel; cmd_sd = sd;
    cmd_burn = burn; cmd_ow = ow; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_data_en = 1'b0; cmd_sel2 = 1'b0; cmd_sd = 1'b0;
    cmd_burn = 1'b0; cmd_ow = 1'b0; cmd_data = '0;
  endtask

  task automatic pulse_reset(input logic blank);
    @(negedge clk);
    rst_n = 1'b0;
    if (blank) blank_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1; blank_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 10_000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_fail++;
    $display("FAIL R3: watchdog, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    pulse_reset(1'b1);
    check("R1 wiper", wiper, 8'h80);
    check("R1 shutdown", shutdown, 0);
    check("R1 status", status, 2'b00);
    check("R1 busy", busy, 0);

    // R2 and R9 vector walk, no trim burned
    for (int i = 0; i < NVEC; i++) begin
      logic [19:0] v;
      v = VEC[i];
      send(v[19], 1'b0, v[18], 1'b0, v[17], v[16:9]);
      check($sformatf("R2/R9 vec%0d wiper", i), wiper, v[8:1]);
      check($sformatf("R9 vec%0d shutdown", i), shutdown, v[0]);
    end

    pulse_reset(1'b0);
    check("R1 preset after power cycle", wiper, 8'h80);

    // R4 burn trim 1, R3 window length
    burn_ok = 1'b1;
    send(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C);
    check("R3 busy after burn cmd", busy, 1);
    wait_idle(cyc);
    check("R3 busy length", cyc, BURN);
    check("R4 status after trim1", status, 2'b11);
    check("R4 wiper fused trim1", wiper, 8'h3C);

    // R5
    send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77);
    check("R5 plain write ignored", wiper, 8'h3C);

    // R6 overwrite and revert
    send(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h77);
    check("R6 overwrite", wiper, 8'h77);
    send(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h78);
    check("R6 overwrite again", wiper, 8'h78);
    send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R6 revert", wiper, 8'h3C);
    send(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hAA);
    pulse_reset(1'b0);
    check("R6 overwrite lost on power cycle", wiper, 8'h3C);
    check("R4 status kept", status, 2'b11);

    // R4 trim 2 after trim 1, R3 command during busy dropped
    send(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3);
    send(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01);
    check("R3 busy during window", busy, 1);
    check("R3 shutdown ignored while busy", shutdown, 0);
    wait_idle(cyc);
    check("R3 shutdown still off", shutdown, 0);
    check("R4 trim2 precedence", wiper, 8'hC3);
    pulse_reset(1'b0);
    check("R4 preset to trim2", wiper, 8'hC3);
    send(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11);
    check("R7 no burn after trim2", busy, 0);

    // R7 trim 2 first locks trim 1
    pulse_reset(1'b1);
    check("R1 fresh die status", status, 2'b00);
    send(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h44);
    wait_idle(cyc);
    check("R7 trim2 first ok", wiper, 8'h44);
    send(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h99);
    check("R7 trim1 refused busy", busy, 0);
    @(negedge clk);
    check("R7 wiper unchanged", wiper, 8'h44);
    check("R7 status", status, 2'b11);

    // R8 fatal lockout
    pulse_reset(1'b1);
    burn_ok = 1'b0;
    send(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
    wait_idle(cyc);
    burn_ok = 1'b1;
    check("R8 fatal status", status, 2'b10);
    check("R8 wiper unfused", wiper, 8'h80);
    send(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h66);
    check("R8 retry refused", busy, 0);
    send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h21);
    check("R8 volatile write still works", wiper, 8'h21);
    pulse_reset(1'b0);
    check("R8 fatal survives power cycle", status, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule